// File: doc/BRIEF.md
# Twelve-Pin GPIO Controller with Level-Sensitive Interrupts

This block is a register-mapped controller for twelve general-purpose pins. It sits behind a simple 32-bit register port made of an address, a write strobe with write data, and a read strobe with combinational read data. Through that port, software drives each pin's output value and output enable, and samples the pins after a two-flop synchronizer. It also stores a 32-bit pin-mux control word, which the block drives out unchanged for routing logic elsewhere.

Each pin can raise an interrupt on a level whose polarity is chosen per pin. While the selected level is present on the synchronized pin, the pin's status bit is latched. The bit stays latched until software writes a 1 to it. If the level is still present at that write, the bit sets again at once, because the set takes priority over the clear. The single interrupt output is raised when any latched status bit is also enabled. A status bit latches whether or not its pin is enabled.

Top module: `gpio12_ctrl`

## Requirements
- R1: After reset the output data, output enable, interrupt enable, status, both polarity registers and the mux register are all zero, and `irq` is low.
- R2: The output data register (offset 0x00) and the output enable register (offset 0x04) keep write-data bits 11:0. These bits drive `pin_out` and `pin_oe` and read back in bits 11:0. Bits 31:12 read as zero.
- R3: Offset 0x08 reads the pins in bits 11:0. The value shown is the pin state from two rising clock edges earlier. Writes to this offset have no effect.
- R4: The polarity bit for pin n sits at bit 4*(n mod 8). For pins 0 to 7 it is in the register at offset 0x10; for pins 8 to 11 it is in the register at offset 0x18. A polarity bit of 0 means active-high and 1 means active-low. Status bit n (offset 0x0C) is set on the first edge after the synchronized pin shows its active level, which is three edges after the pin changes.
- R5: A status bit stays set after its level goes away. Only a write of 1 to that bit at offset 0x0C clears it. Writing 0 to a status bit leaves it unchanged.
- R6: If a status bit is cleared while its pin still shows the active level, the bit still reads as set after the write, because a set on the same edge wins over the clear.
- R7: The interrupt enable register sits at offset 0x14. A 1 in bit n unmasks pin n, and reset leaves every pin masked. `irq` is high exactly when some status bit and its enable bit are both 1.
- R8: The mux register at offset 0x1C keeps all 32 bits. It reads back and drives `mux_sel` with no other effect.
- R9: The polarity registers read back all 32 written bits, and only the per-pin bits affect interrupts. Offsets not listed above read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd`, zero otherwise |
| pin_in | input | 12 | Asynchronous pin levels |
| pin_out | output | 12 | Output data to the pads |
| pin_oe | output | 12 | Per-pin output enable |
| mux_sel | output | 32 | Stored pin-mux control word |
| irq | output | 1 | Combined level interrupt |

## Verification
A register write takes effect on the edge that samples the strobe. Its effect on `pin_out`, `pin_oe`, `mux_sel`, read data and `irq` is visible in the next cycle. A pin change reaches the input register two edges later and the status register three edges later. The bench drives every input at the falling edge and counts edges from there. It checks status to be still clear after two edges and set after the third. A read is combinational, so the bench samples it a short delay after raising the read strobe, without an intervening edge.

// File: rtl/gpio12_pkg.sv
// Shared constants for the twelve-pin GPIO controller.
// Assumes a byte-addressed register port with word-aligned accesses.
package gpio12_pkg;
    localparam int NUM_PINS   = 12;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int POL_STRIDE = 4;
    localparam int POL_GROUP  = 8;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] OFF_DOUT = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_OE   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_DIN  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_POLA = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_IEN  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_POLB = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_MUX  = 8'h1C;
endpackage

// File: rtl/gpio12_sync.sv
// Multi-stage synchronizer for asynchronous pin levels.
// Assumes each bit is independent; no bus coherency is provided.
module gpio12_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stg [STAGES];

    // Shift the pin levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/gpio12_irq.sv
// Level interrupt latch: compares synchronized pins with per-pin polarity,
// latches status, applies write-1 clears (set wins) and forms the interrupt.
// Assumes pol_vec and clr_vec are already decoded per pin.
module gpio12_irq #(
    parameter int NPINS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins_sync,
    input  logic [NPINS-1:0] pol_vec,
    input  logic [NPINS-1:0] clr_vec,
    input  logic [NPINS-1:0] en_vec,
    output logic [NPINS-1:0] status,
    output logic             irq
);
    logic [NPINS-1:0] lvl;
    logic [NPINS-1:0] st_q;

    // Active level: pin high with polarity 0, pin low with polarity 1.
    always_comb lvl = pins_sync ^ pol_vec;

    // Latch status; a fresh level on the same edge overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr_vec) | lvl;
    end

    // Combine enabled status bits into the single interrupt.
    always_comb irq = |(st_q & en_vec);

    assign status = st_q;

    p_set_on_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != '0) |=> ((st_q & $past(lvl)) == $past(lvl)));

    p_hold_until_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(st_q) & ~st_q) & ~$past(clr_vec)) == '0));

    p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & lvl) != '0) |=> ((st_q & $past(clr_vec & lvl)) == $past(clr_vec & lvl)));
endmodule

// File: rtl/gpio12_regs.sv
// Register file and read multiplexer for the GPIO controller.
// Assumes single-cycle write strobes and combinational reads.
module gpio12_regs
    import gpio12_pkg::*;
#(
    parameter int NPINS = NUM_PINS,
    parameter int DW    = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_rd,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NPINS-1:0]  pins_sync,
    input  logic [NPINS-1:0]  status,
    output logic [NPINS-1:0]  out_q,
    output logic [NPINS-1:0]  oe_q,
    output logic [NPINS-1:0]  en_q,
    output logic [DW-1:0]     mux_q,
    output logic [NPINS-1:0]  pol_vec,
    output logic [NPINS-1:0]  clr_vec
);
    localparam int PAD = DW - NPINS;

    logic [DW-1:0] pola_q;
    logic [DW-1:0] polb_q;

    // Capture writes into the writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            oe_q   <= '0;
            en_q   <= '0;
            pola_q <= '0;
            polb_q <= '0;
            mux_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFF_DOUT: out_q  <= bus_wdata[NPINS-1:0];
                OFF_OE:   oe_q   <= bus_wdata[NPINS-1:0];
                OFF_IEN:  en_q   <= bus_wdata[NPINS-1:0];
                OFF_POLA: pola_q <= bus_wdata;
                OFF_POLB: polb_q <= bus_wdata;
                OFF_MUX:  mux_q  <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Pick each pin's polarity bit out of the two polarity registers.
    for (genvar n = 0; n < NPINS; n++) begin : g_pol
        if (n < POL_GROUP) begin : g_lo
            assign pol_vec[n] = pola_q[POL_STRIDE*n];
        end else begin : g_hi
            assign pol_vec[n] = polb_q[POL_STRIDE*(n-POL_GROUP)];
        end
    end

    // Write-one-to-clear request for the status latch.
    always_comb clr_vec = (bus_wr && bus_addr == OFF_STAT) ? bus_wdata[NPINS-1:0] : '0;

    // Read multiplexer; unmapped offsets and idle cycles return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFF_DOUT: bus_rdata = {{PAD{1'b0}}, out_q};
                OFF_OE:   bus_rdata = {{PAD{1'b0}}, oe_q};
                OFF_DIN:  bus_rdata = {{PAD{1'b0}}, pins_sync};
                OFF_STAT: bus_rdata = {{PAD{1'b0}}, status};
                OFF_POLA: bus_rdata = pola_q;
                OFF_IEN:  bus_rdata = {{PAD{1'b0}}, en_q};
                OFF_POLB: bus_rdata = polb_q;
                OFF_MUX:  bus_rdata = mux_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (out_q == '0 && oe_q == '0 && en_q == '0 && mux_q == '0));

    p_oe_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_OE) |=> (oe_q == $past(bus_wdata[NPINS-1:0])));

    p_mux_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_MUX) |=> (mux_q == $past(bus_wdata)));
endmodule

// File: rtl/gpio12_ctrl.sv
// Top of the twelve-pin GPIO controller: synchronizer, register file and
// level interrupt latch. Assumes pads and mux routing live outside.
module gpio12_ctrl
    import gpio12_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [DATA_W-1:0]   mux_sel,
    output logic                irq
);
    logic [NUM_PINS-1:0] pins_sync;
    logic [NUM_PINS-1:0] status;
    logic [NUM_PINS-1:0] en_q;
    logic [NUM_PINS-1:0] pol_vec;
    logic [NUM_PINS-1:0] clr_vec;

    gpio12_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pins_sync)
    );

    gpio12_regs #(.NPINS(NUM_PINS), .DW(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pins_sync (pins_sync),
        .status    (status),
        .out_q     (pin_out),
        .oe_q      (pin_oe),
        .en_q      (en_q),
        .mux_q     (mux_sel),
        .pol_vec   (pol_vec),
        .clr_vec   (clr_vec)
    );

    gpio12_irq #(.NPINS(NUM_PINS)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_sync (pins_sync),
        .pol_vec   (pol_vec),
        .clr_vec   (clr_vec),
        .en_vec    (en_q),
        .status    (status),
        .irq       (irq)
    );

    p_irq_needs_enabled_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((status & en_q) != '0));
endmodule

// File: tb/gpio12_ctrl_tb.sv
module gpio12_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [11:0] pin_in = '0;
    logic [11:0] pin_out;
    logic [11:0] pin_oe;
    logic [31:0] mux_sel;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio12_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .mux_sel(mux_sel), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        logic [11:0] base;
        logic [11:0] bitn;
        tick(3);
        // R1: reset values
        rd(8'h00, v); chk("R1 dout", v, 0);
        rd(8'h04, v); chk("R1 oe", v, 0);
        rd(8'h0C, v); chk("R1 status", v, 0);
        rd(8'h10, v); chk("R1 pola", v, 0);
        rd(8'h14, v); chk("R1 ien", v, 0);
        rd(8'h18, v); chk("R1 polb", v, 0);
        rd(8'h1C, v); chk("R1 mux", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 pin_out", {20'd0, pin_out}, 0);
        chk("R1 pin_oe", {20'd0, pin_oe}, 0);
        chk("R1 mux_sel", mux_sel, 0);

        // R2: output data and enable registers
        for (int k = 0; k < 8; k++) begin
            logic [31:0] d;
            d = 32'hA5C3_F00F ^ (32'h1357_9BDF * (k + 1));
            wr(8'h00, d);
            rd(8'h00, v); chk("R2 dout readback", v, {20'd0, d[11:0]});
            chk("R2 pin_out", {20'd0, pin_out}, {20'd0, d[11:0]});
            wr(8'h04, ~d);
            rd(8'h04, v); chk("R2 oe readback", v, {20'd0, ~d[11:0]});
            chk("R2 pin_oe", {20'd0, pin_oe}, {20'd0, ~d[11:0]});
        end

        // R8: mux register
        for (int k = 0; k < 6; k++) begin
            logic [31:0] d;
            d = 32'hDEAD_BEEF + 32'h0F1E_2D3C * k;
            wr(8'h1C, d);
            rd(8'h1C, v); chk("R8 mux readback", v, d);
            chk("R8 mux_sel", mux_sel, d);
        end

        // R9: polarity non-pin bits read back but do not act; unmapped reads zero
        wr(8'h10, 32'hEEEE_EEEE);
        wr(8'h18, 32'hFFFF_EEEE);
        rd(8'h10, v); chk("R9 pola readback", v, 32'hEEEE_EEEE);
        rd(8'h18, v); chk("R9 polb readback", v, 32'hFFFF_EEEE);
        tick(4);
        rd(8'h0C, v); chk("R9 status unaffected", v, 0);
        rd(8'h20, v); chk("R9 unmapped 0x20", v, 0);
        rd(8'h40, v); chk("R9 unmapped 0x40", v, 0);
        rd(8'hFC, v); chk("R9 unmapped 0xFC", v, 0);
        rd(8'h02, v); chk("R9 unmapped 0x02", v, 0);
        wr(8'h10, 0);
        wr(8'h18, 0);

        // R3: input register, two-edge latency, writes ignored
        for (int k = 0; k < 16; k++) begin
            logic [11:0] p;
            p = 12'(12'h9A5 * k + 12'h3C3);
            pin_in = p;
            tick(2);
            rd(8'h08, v); chk("R3 input", v, {20'd0, p});
            wr(8'h08, {20'd0, ~p});
            rd(8'h08, v); chk("R3 write ignored", v, {20'd0, p});
        end

        // R4..R7: per-pin, per-polarity sweep
        for (int n = 0; n < 12; n++) begin
            for (int p = 0; p < 2; p++) begin
                bitn = 12'(1 << n);
                base = (p == 1) ? bitn : 12'h000;
                pin_in = base;
                wr(8'h14, 0);
                if (n < 8) begin
                    wr(8'h10, 32'(p) << (4 * n)); wr(8'h18, 0);
                end else begin
                    wr(8'h10, 0); wr(8'h18, 32'(p) << (4 * (n - 8)));
                end
                tick(3);
                wr(8'h0C, 32'hFFF);
                rd(8'h0C, v); chk("R4 idle status", v, 0);
                pin_in = base ^ bitn;
                tick(2);
                rd(8'h0C, v); chk("R4 not yet set", v, 0);
                tick(1);
                rd(8'h0C, v); chk("R4 status set", v, {20'd0, bitn});
                chk("R7 masked irq", {31'd0, irq}, 0);
                wr(8'h14, {20'd0, bitn});
                chk("R7 enabled irq", {31'd0, irq}, 1);
                wr(8'h14, {20'd0, ~bitn});
                chk("R7 other enables irq", {31'd0, irq}, 0);
                wr(8'h14, 0);
                wr(8'h0C, {20'd0, bitn});
                rd(8'h0C, v); chk("R6 reasserts", v, {20'd0, bitn});
                pin_in = base;
                tick(3);
                rd(8'h0C, v); chk("R5 latched", v, {20'd0, bitn});
                wr(8'h0C, 0);
                rd(8'h0C, v); chk("R5 zero write", v, {20'd0, bitn});
                wr(8'h0C, {20'd0, bitn});
                rd(8'h0C, v); chk("R5 cleared", v, 0);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule